// File: doc/BRIEF.md
# Partial-Register Aliased Register File

This block holds eight 32-bit general registers. Each can be reached through narrower names that cover part of the same storage. Registers 0 to 3 (a, b, c, d) can be accessed four ways: whole, as their low half, as their low byte, or as the byte in bits 15:8. Registers 4 to 7 (sp, bp, si, di) can be accessed only whole or as their low half. A narrow write replaces only the bits its name covers. The rest of the register keeps its value.

There is one write port. Each write request carries an operation code, a destination size, a destination, a source register with its own size, and an immediate. The operations are move from a register, move from the immediate, byte add and byte subtract. A decode stage checks the request. It turns a legal request into a small set of strobes for the datapath. It raises a flag for a request it cannot carry out, and that request changes nothing. Two independent read ports return the selected slice, zero-extended to 32 bits.

Top module: `aliasRegFile`

## Requirements
- R1: Each read port returns the slice selected by its size code, zero-extended to 32 bits, combinationally. The size codes are: 0 = bits 31:0, 1 = bits 15:0, 2 = bits 7:0, 3 = bits 15:8 placed in result bits 7:0. Register indices are 0 a, 1 b, 2 c, 3 d, 4 sp, 5 bp, 6 si, 7 di.
- R2: A committed write with size 1, 2 or 3 changes only the bits that size names. Every other bit of the destination keeps its value.
- R3: A committed write changes only the destination register, and the change appears after the next rising clock edge.
- R4: Op 0 copies the source slice into the destination slice. Source and destination must be the same width, and any byte alias may be copied to any byte alias (high to low, high to high, and so on). Op 1 writes the low bits of the immediate into the destination slice, at any size.
- R5: Op 2 adds and op 4 subtracts a register byte into a destination byte. Op 3 adds and op 5 subtracts the low byte of the immediate. All four wrap modulo 256, and the carry or borrow never reaches the other byte of the register.
- R6: `wrIllegal` is high, combinationally, while `wrEn` is high and any of these holds: the op code is 6 or 7; a byte size is used on registers 4 to 7, as destination or as a register source; a register-source op has source and destination of different widths; an add or subtract uses a size other than 2 or 3. Such a request leaves every register unchanged.
- R7: A byte-alias read (size 2 or 3) of registers 4 to 7 returns zero.
- R8: Reset (active low) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write request valid |
| wrOp | input | 3 | Operation code (0..5 legal) |
| wrSize | input | 2 | Destination size code |
| wrDst | input | 3 | Destination register index |
| wrSrc | input | 3 | Source register index |
| wrSrcSize | input | 2 | Source size code for register-source ops |
| wrImm | input | 32 | Immediate operand |
| wrIllegal | output | 1 | Current write request is rejected |
| rdAddrA | input | 3 | Read port A register index |
| rdSizeA | input | 2 | Read port A size code |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdAddrB | input | 3 | Read port B register index |
| rdSizeB | input | 2 | Read port B size code |
| rdDataB | output | 32 | Read port B data, zero-extended |

## Verification
The assertions assume that every write-side input is known whenever reset is released, and that reset is held across at least one rising edge before the first request. The bench drives every input to zero from time zero and holds reset for several edges. It changes inputs only shortly after a rising edge, so the decode strobes are stable when the edge samples them. Illegal requests are sent on purpose, covering each reject condition. The registers they could have corrupted are then read back through the normal read ports.

// File: rtl/aliasrf_pkg.sv
`timescale 1ns/1ps
package aliasrf_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int BYTE_REGS = 4;
  localparam int HALF_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int OP_W      = 3;
  localparam int SZ_W      = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_FULL = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LOW  = 2'd2,
    SZ_HIGH = 2'd3
  } sizeSel_e;

  typedef enum logic [OP_W-1:0] {
    OP_MOVR = 3'd0,
    OP_MOVI = 3'd1,
    OP_ADDR = 3'd2,
    OP_ADDI = 3'd3,
    OP_SUBR = 3'd4,
    OP_SUBI = 3'd5
  } opCode_e;

  typedef struct packed {
    logic             commit;
    sizeSel_e         dstSize;
    sizeSel_e         srcSize;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    logic             useImm;
    logic             doArith;
    logic             doSub;
  } ctrlStb_t;

  function automatic logic isByte(sizeSel_e s);
    return s == SZ_LOW || s == SZ_HIGH;
  endfunction

  // Width class: byte aliases form one class, full and half are their own.
  function automatic logic [1:0] widthClass(sizeSel_e s);
    case (s)
      SZ_FULL: return 2'd0;
      SZ_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pickSlice(logic [DATA_W-1:0] word, sizeSel_e s);
    case (s)
      SZ_FULL: return word;
      SZ_HALF: return DATA_W'(word[HALF_W-1:0]);
      SZ_LOW:  return DATA_W'(word[BYTE_W-1:0]);
      default: return DATA_W'(word[HALF_W-1:BYTE_W]);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mergeSlice(logic [DATA_W-1:0] word,
                                                   logic [DATA_W-1:0] val,
                                                   sizeSel_e s);
    logic [DATA_W-1:0] r;
    r = word;
    case (s)
      SZ_FULL: r = val;
      SZ_HALF: r[HALF_W-1:0] = val[HALF_W-1:0];
      SZ_LOW:  r[BYTE_W-1:0] = val[BYTE_W-1:0];
      default: r[HALF_W-1:BYTE_W] = val[BYTE_W-1:0];
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] sliceMask(sizeSel_e s);
    case (s)
      SZ_FULL: return {DATA_W{1'b1}};
      SZ_HALF: return DATA_W'({HALF_W{1'b1}});
      SZ_LOW:  return DATA_W'({BYTE_W{1'b1}});
      default: return DATA_W'({BYTE_W{1'b1}}) << BYTE_W;
    endcase
  endfunction
endpackage

// File: rtl/aliasrf_ctrl.sv
`timescale 1ns/1ps
module aliasrf_ctrl
  import aliasrf_pkg::*;
(
  input  logic             wrEn,
  input  logic [OP_W-1:0]  wrOp,
  input  logic [SZ_W-1:0]  wrSize,
  input  logic [IDX_W-1:0] wrDst,
  input  logic [IDX_W-1:0] wrSrc,
  input  logic [SZ_W-1:0]  wrSrcSize,
  output ctrlStb_t         stb,
  output logic             illegal
);
  localparam logic [IDX_W-1:0] FIRST_WIDE_ONLY = IDX_W'(BYTE_REGS);

  sizeSel_e dstSize;
  sizeSel_e srcSize;
  logic     knownOp;
  logic     regSource;
  logic     arith;
  logic     subtract;
  logic     dstAliasBad;
  logic     srcAliasBad;
  logic     widthMismatch;
  logic     arithTooWide;
  logic     reject;

  assign dstSize = sizeSel_e'(wrSize);
  assign srcSize = sizeSel_e'(wrSrcSize);

  always_comb begin
    knownOp   = 1'b1;
    regSource = 1'b0;
    arith     = 1'b0;
    subtract  = 1'b0;
    case (wrOp)
      OP_MOVR: regSource = 1'b1;
      OP_MOVI: ;
      OP_ADDR: begin regSource = 1'b1; arith = 1'b1; end
      OP_ADDI: arith = 1'b1;
      OP_SUBR: begin regSource = 1'b1; arith = 1'b1; subtract = 1'b1; end
      OP_SUBI: begin arith = 1'b1; subtract = 1'b1; end
      default: knownOp = 1'b0;
    endcase
  end

  assign dstAliasBad   = isByte(dstSize) && (wrDst >= FIRST_WIDE_ONLY);
  assign srcAliasBad   = regSource && isByte(srcSize) && (wrSrc >= FIRST_WIDE_ONLY);
  assign widthMismatch = regSource && (widthClass(srcSize) != widthClass(dstSize));
  assign arithTooWide  = arith && !isByte(dstSize);
  assign reject        = !knownOp || dstAliasBad || srcAliasBad || widthMismatch || arithTooWide;

  assign illegal = wrEn && reject;

  always_comb begin
    stb.commit  = wrEn && !reject;
    stb.dstSize = dstSize;
    stb.srcSize = srcSize;
    stb.dst     = wrDst;
    stb.src     = wrSrc;
    stb.useImm  = !regSource;
    stb.doArith = arith;
    stb.doSub   = subtract;
  end
endmodule

// File: rtl/aliasrf_dp.sv
`timescale 1ns/1ps
module aliasrf_dp
  import aliasrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] imm,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [SZ_W-1:0]   rdSizeA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  input  logic [SZ_W-1:0]   rdSizeB,
  output logic [DATA_W-1:0] rdDataB
);
  localparam logic [IDX_W-1:0] FIRST_WIDE_ONLY = IDX_W'(BYTE_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0] dstWord;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] dstSlice;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] resultVal;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] wrMask;

  function automatic logic [DATA_W-1:0] readView(logic [DATA_W-1:0] word,
                                                 logic [IDX_W-1:0] addr,
                                                 logic [SZ_W-1:0] size);
    sizeSel_e s;
    s = sizeSel_e'(size);
    if (isByte(s) && addr >= FIRST_WIDE_ONLY) return '0;
    return pickSlice(word, s);
  endfunction

  assign rdDataA = readView(regFile[rdAddrA], rdAddrA, rdSizeA);
  assign rdDataB = readView(regFile[rdAddrB], rdAddrB, rdSizeB);

  // Operand path; for byte results only the low byte survives the merge,
  // so the carry or borrow out of bit 7 is dropped.
  assign dstWord   = regFile[stb.dst];
  assign srcVal    = stb.useImm ? imm : pickSlice(regFile[stb.src], stb.srcSize);
  assign dstSlice  = pickSlice(dstWord, stb.dstSize);
  assign sumVal    = stb.doSub ? (dstSlice - srcVal) : (dstSlice + srcVal);
  assign resultVal = stb.doArith ? sumVal : srcVal;
  assign nextWord  = mergeSlice(dstWord, resultVal, stb.dstSize);
  assign wrMask    = sliceMask(stb.dstSize);

  always_ff @(posedge clk) begin
    if (!rstN) regFile <= '0;
    else if (stb.commit) regFile[stb.dst] <= nextWord;
  end

  // R2: bits outside the written slice survive a commit.
  p_slice_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> ((regFile[$past(stb.dst)] & ~$past(wrMask)) ==
                    ($past(dstWord) & ~$past(wrMask))));

  // R3: registers other than the destination never move on a commit.
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_keep
    p_others_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
      (stb.commit && stb.dst != IDX_W'(gi)) |=> (regFile[gi] == $past(regFile[gi])));
  end

  // R4: a register move lands the source slice in the destination slice.
  p_move_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !stb.doArith && !stb.useImm) |=>
      (pickSlice(regFile[$past(stb.dst)], $past(stb.dstSize)) == $past(srcVal)));

  // R6: without a commit (idle or rejected), the whole file holds.
  p_hold_no_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> (regFile == $past(regFile)));
endmodule

// File: rtl/aliasRegFile.sv
`timescale 1ns/1ps
module aliasRegFile
  import aliasrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OP_W-1:0]   wrOp,
  input  logic [SZ_W-1:0]   wrSize,
  input  logic [IDX_W-1:0]  wrDst,
  input  logic [IDX_W-1:0]  wrSrc,
  input  logic [SZ_W-1:0]   wrSrcSize,
  input  logic [DATA_W-1:0] wrImm,
  output logic              wrIllegal,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [SZ_W-1:0]   rdSizeA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  input  logic [SZ_W-1:0]   rdSizeB,
  output logic [DATA_W-1:0] rdDataB
);
  ctrlStb_t stb;

  aliasrf_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrOp      (wrOp),
    .wrSize    (wrSize),
    .wrDst     (wrDst),
    .wrSrc     (wrSrc),
    .wrSrcSize (wrSrcSize),
    .stb       (stb),
    .illegal   (wrIllegal)
  );

  aliasrf_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .imm     (wrImm),
    .rdAddrA (rdAddrA),
    .rdSizeA (rdSizeA),
    .rdDataA (rdDataA),
    .rdAddrB (rdAddrB),
    .rdSizeB (rdSizeB),
    .rdDataB (rdDataB)
  );
endmodule

// File: tb/tb_aliasRegFile.sv
`timescale 1ns/1ps
module tb_aliasRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrOp = '0;
  logic [1:0]  wrSize = '0;
  logic [2:0]  wrDst = '0;
  logic [2:0]  wrSrc = '0;
  logic [1:0]  wrSrcSize = '0;
  logic [31:0] wrImm = '0;
  logic        wrIllegal;
  logic [2:0]  rdAddrA = '0;
  logic [1:0]  rdSizeA = '0;
  logic [31:0] rdDataA;
  logic [2:0]  rdAddrB = '0;
  logic [1:0]  rdSizeB = '0;
  logic [31:0] rdDataB;

  aliasRegFile dut (.*);

  always #5 clk = ~clk;

  typedef struct { int kind; int req; logic [31:0] exp; } item_t;
  item_t       sbq[$];
  item_t       cur;
  logic [31:0] act;
  int          nCmp = 0;
  int          nBad = 0;
  bit          pend = 1'b0;
  bit          done = 1'b0;
  logic [31:0] model [8];

  // Monitor: pops expected items and compares with the ports.
  always @(negedge clk) begin
    if (pend) begin
      while (sbq.size() > 0) begin
        cur = sbq.pop_front();
        case (cur.kind)
          0:       act = rdDataA;
          1:       act = rdDataB;
          default: act = {31'b0, wrIllegal};
        endcase
        nCmp++;
        if (act !== cur.exp) begin
          nBad++;
          $display("FAIL R%0d (port kind %0d): actual %h expected %h", cur.req, cur.kind, act, cur.exp);
        end
      end
      pend = 1'b0;
    end
  end

  function automatic logic [31:0] sliceOf(logic [31:0] w, logic [1:0] s);
    case (s)
      2'd0: return w;
      2'd1: return {16'h0, w[15:0]};
      2'd2: return {24'h0, w[7:0]};
      default: return {24'h0, w[15:8]};
    endcase
  endfunction

  function automatic logic [31:0] putSlice(logic [31:0] w, logic [31:0] v, logic [1:0] s);
    logic [31:0] r = w;
    case (s)
      2'd0: r = v;
      2'd1: r[15:0] = v[15:0];
      2'd2: r[7:0] = v[7:0];
      default: r[15:8] = v[7:0];
    endcase
    return r;
  endfunction

  task automatic push(int k, int r, logic [31:0] e);
    item_t it;
    it.kind = k; it.req = r; it.exp = e;
    sbq.push_back(it);
  endtask

  // Driver: read two slices, expectation supplied or taken from the model.
  task automatic readPair(logic [2:0] a, logic [1:0] sa, logic [31:0] ea,
                          logic [2:0] b, logic [1:0] sb, logic [31:0] eb, int r);
    @(posedge clk); #1;
    rdAddrA = a; rdSizeA = sa; rdAddrB = b; rdSizeB = sb;
    push(0, r, ea); push(1, r, eb);
    pend = 1'b1;
  endtask

  task automatic readModel(logic [2:0] a, logic [1:0] sa, int r);
    readPair(a, sa, sliceOf(model[a], sa), a, 2'd0, model[a], r);
  endtask

  task automatic doWrite(logic [2:0] op, logic [1:0] sz, logic [2:0] dst,
                         logic [2:0] src, logic [1:0] ssz, logic [31:0] imm,
                         bit expIll, int r);
    logic [31:0] sv;
    logic [7:0]  db;
    logic [31:0] res;
    @(posedge clk); #1;
    wrEn = 1'b1; wrOp = op; wrSize = sz; wrDst = dst; wrSrc = src;
    wrSrcSize = ssz; wrImm = imm;
    push(2, r, {31'b0, expIll});
    pend = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (!expIll) begin
      sv = op[0] ? imm : sliceOf(model[src], ssz);
      db = sliceOf(model[dst], sz)[7:0];
      if (op == 3'd2 || op == 3'd3) res = {24'h0, db + sv[7:0]};
      else if (op == 3'd4 || op == 3'd5) res = {24'h0, db - sv[7:0]};
      else res = sv;
      model[dst] = putSlice(model[dst], res, sz);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R8: everything reads zero after reset
    for (int i = 0; i < 8; i += 2) readPair(3'(i), 2'd0, 32'h0, 3'(i + 1), 2'd0, 32'h0, 8);

    // R1 / R4: immediate full write, then every view of it
    doWrite(3'd1, 2'd0, 3'd0, 3'd0, 2'd0, 32'h11223344, 1'b0, 4);
    readPair(3'd0, 2'd1, 32'h00003344, 3'd0, 2'd2, 32'h00000044, 1);
    readPair(3'd0, 2'd3, 32'h00000033, 3'd0, 2'd0, 32'h11223344, 1);
    // R2: low byte then high byte immediates keep other bits
    doWrite(3'd1, 2'd2, 3'd0, 3'd0, 2'd0, 32'hFFFFFFAA, 1'b0, 2);
    readPair(3'd0, 2'd0, 32'h112233AA, 3'd0, 2'd1, 32'h000033AA, 2);
    doWrite(3'd1, 2'd3, 3'd0, 3'd0, 2'd0, 32'h000000BB, 1'b0, 2);
    readPair(3'd0, 2'd0, 32'h1122BBAA, 3'd1, 2'd0, 32'h0, 3); // R3: b untouched
    // R2: half write on sp keeps upper half
    doWrite(3'd1, 2'd0, 3'd4, 3'd0, 2'd0, 32'hCAFEF00D, 1'b0, 4);
    doWrite(3'd1, 2'd1, 3'd4, 3'd0, 2'd0, 32'h00001234, 1'b0, 2);
    readPair(3'd4, 2'd0, 32'hCAFE1234, 3'd4, 2'd1, 32'h00001234, 2);
    // R7: byte views of sp read zero
    readPair(3'd4, 2'd2, 32'h0, 3'd4, 2'd3, 32'h0, 7);
    // R6: byte write to sp rejected, sp unchanged
    doWrite(3'd1, 2'd2, 3'd4, 3'd0, 2'd0, 32'h55, 1'b1, 6);
    readPair(3'd4, 2'd0, 32'hCAFE1234, 3'd0, 2'd0, 32'h1122BBAA, 6);
    // R6: full-width add, width mismatch, byte source of si, op 7
    doWrite(3'd3, 2'd0, 3'd0, 3'd0, 2'd0, 32'h1, 1'b1, 6);
    doWrite(3'd0, 2'd1, 3'd1, 3'd0, 2'd0, 32'h0, 1'b1, 6);
    doWrite(3'd2, 2'd2, 3'd1, 3'd6, 2'd2, 32'h0, 1'b1, 6);
    doWrite(3'd7, 2'd0, 3'd2, 3'd0, 2'd0, 32'h0, 1'b1, 6);
    readPair(3'd1, 2'd0, 32'h0, 3'd2, 2'd0, 32'h0, 6);
    // R4: register moves at each width and across byte aliases
    doWrite(3'd0, 2'd0, 3'd5, 3'd0, 2'd0, 32'h0, 1'b0, 4);
    readModel(3'd5, 2'd0, 4);
    doWrite(3'd0, 2'd1, 3'd7, 3'd4, 2'd1, 32'h0, 1'b0, 4);
    readModel(3'd7, 2'd1, 4);
    doWrite(3'd0, 2'd3, 3'd1, 3'd0, 2'd3, 32'h0, 1'b0, 4);
    doWrite(3'd0, 2'd2, 3'd1, 3'd0, 2'd3, 32'h0, 1'b0, 4);
    readPair(3'd1, 2'd0, 32'h0000BBBB, 3'd0, 2'd0, 32'h1122BBAA, 4);
    // R5: byte add wraps, high byte untouched
    doWrite(3'd1, 2'd0, 3'd2, 3'd0, 2'd0, 32'h7777_44F0, 1'b0, 4);
    doWrite(3'd3, 2'd2, 3'd2, 3'd0, 2'd0, 32'h00000020, 1'b0, 5);
    readPair(3'd2, 2'd0, 32'h77774410, 3'd2, 2'd2, 32'h10, 5);
    // R5: high byte add wraps without touching bits 31:16
    doWrite(3'd3, 2'd3, 3'd2, 3'd0, 2'd0, 32'h000000C0, 1'b0, 5);
    readPair(3'd2, 2'd0, 32'h77770410, 3'd2, 2'd3, 32'h04, 5);
    // R5: subtract borrow stays in the byte
    doWrite(3'd1, 2'd0, 3'd3, 3'd0, 2'd0, 32'h0000_0105, 1'b0, 4);
    doWrite(3'd5, 2'd2, 3'd3, 3'd0, 2'd0, 32'h00000010, 1'b0, 5);
    readPair(3'd3, 2'd0, 32'h000001F5, 3'd3, 2'd2, 32'hF5, 5);
    // R5: register-source byte add and subtract (hi into lo)
    doWrite(3'd2, 2'd2, 3'd3, 3'd2, 2'd3, 32'h0, 1'b0, 5);
    readModel(3'd3, 2'd2, 5);
    doWrite(3'd4, 2'd3, 3'd3, 3'd0, 2'd2, 32'h0, 1'b0, 5);
    readModel(3'd3, 2'd3, 5);
    // R3: final sweep of all registers against the model
    for (int i = 0; i < 8; i++) readModel(3'(i), 2'd1, 3);
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nBad++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule